// File: doc/BRIEF.md
# DMA Completion Response Queue

This block keeps one completion record for each descriptor that a DMA engine finishes. A record holds the number of bytes moved, an 8-bit error code and a flag for early termination. The engine hands records in over a valid/ready port. Software takes them out through a small read window of two 32-bit words. The byte count is at offset 0x00 and the status word is at offset 0x04.

Reading the byte-count word does not change the queue, so software may read it first and as often as it likes. Reading the status word returns the status and also retires the head record. A full record is therefore consumed with exactly two reads, byte count first and status last.

The queue also drives a 16-bit fill level and its empty and full flags to the status register block. It keeps a sticky overflow flag, which is set when the engine offers a record while the queue is full.

Back-pressure rules: `rsp_ready` is high whenever the queue has a free slot. A record is taken on a clock edge where both `rsp_valid` and `rsp_ready` are high. A record offered while `rsp_ready` is low is discarded and is never retained. The producer is expected to hold off while `rsp_ready` is low.

Top module: `dma_resp_queue`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `q_level`=0, `q_overflow`=0 and `rsp_ready`=1.
- R2: A record offered with `rsp_valid` and `rsp_ready` both high is stored, and `q_level` rises by one at the following edge when no pop occurs in the same cycle.
- R3: A record offered while the queue is full is dropped. `q_level` and the stored records stay unchanged, and `q_overflow` goes to 1 and stays at 1 until reset.
- R4: A read at offset 0x00 returns the head record's byte count, zero-extended to 32 bits. It removes nothing, and repeating it returns the same value.
- R5: A read at offset 0x04 returns the head status with the error code in bits 7:0, the early-termination flag in bit 8 and zeros above. The head record is then removed, so `q_level` falls by one.
- R6: Records leave the queue in the order they were accepted.
- R7: A read at either offset while the queue is empty returns zero and leaves `q_level` at 0. Later pushes and reads behave normally.
- R8: Read data appears on `rd_data` with `rd_valid`=1 on the cycle after the edge that samples `rd_en`. `rd_valid` is 0 when there was no read.
- R9: `q_full` is 1 exactly when `q_level` equals DEPTH, and `rsp_ready` is low while `q_full` is 1. `q_empty` is 1 exactly when `q_level` is 0.
- R10: A read at any offset other than 0x00 or 0x04 returns zero and removes nothing.
- R11: A push and a status read in the same cycle on a non-full queue keep `q_level` unchanged. The read returns the old head.
- R12: `q_level` is the current record count as an unsigned 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Engine offers a completion record |
| rsp_ready | output | 1 | Queue has a free slot |
| rsp_bytes | input | BYTES_W | Bytes transferred |
| rsp_err | input | 8 | Error code |
| rsp_early | input | 1 | Early-termination flag |
| rd_en | input | 1 | Read strobe for the window |
| rd_addr | input | ADDR_W | Byte offset in the window |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | `rd_data` holds the result of a read |
| q_level | output | 16 | Current record count |
| q_empty | output | 1 | Queue holds no record |
| q_full | output | 1 | Queue holds DEPTH records |
| q_overflow | output | 1 | Sticky: a record was dropped while the queue was full |

## Verification
A wrong pointer or count appears at the ports within one read. A slipped read pointer returns another record's byte count or status on the next window read. A miscounted level shows at once on `q_level` or the flags, and it makes `rsp_ready` deny or allow a push it should not. Popping on the byte-count word instead of the status word is caught at the next byte-count read, because the second read returns a different record. A lost overflow bit is caught on the cycle after the dropped push.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;

  localparam int ERR_W        = 8;
  localparam int EARLY_BIT    = 8;
  localparam int WORD_W       = 32;
  localparam int OFS_BYTES    = 0;
  localparam int OFS_STATUS   = 4;
  localparam int LEVEL_W      = 16;

  typedef struct packed {
    logic             early;
    logic [ERR_W-1:0] err;
  } resp_stat_t;

  // status word layout: err in [7:0], early in [8]
  function automatic logic [WORD_W-1:0] stat_word(resp_stat_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ERR_W-1:0] = s.err;
    w[EARLY_BIT] = s.early;
    return w;
  endfunction

endpackage

// File: rtl/resp_push_guard.sv
module resp_push_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic store_full,
  output logic in_ready,
  output logic accept,
  output logic overflow
);
  logic ovf_q;

  assign in_ready = ~store_full;
  assign accept   = in_valid & ~store_full;

  always_ff @(posedge clk) begin
    if (!rst_n)                       ovf_q <= 1'b0;
    else if (in_valid && store_full)  ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/resp_store.sv
module resp_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 41,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              do_wr, do_rd;

  assign do_wr = wr_en & (cnt != CMAX);
  assign do_rd = pop & (cnt != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && wp == PTR_W'(i)) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = slot[rp];
  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CMAX);
endmodule

// File: rtl/resp_window.sv
module resp_window
  import dma_resp_pkg::*;
#(
  parameter int BYTES_W = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               empty,
  input  logic [BYTES_W-1:0] head_bytes,
  input  resp_stat_t         head_stat,
  output logic               pop,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic [WORD_W-1:0] bytes_word, sel_word;
  logic              hit_bytes, hit_stat;

  if (BYTES_W < WORD_W) begin : g_pad
    assign bytes_word = {{(WORD_W-BYTES_W){1'b0}}, head_bytes};
  end else begin : g_full
    assign bytes_word = head_bytes[WORD_W-1:0];
  end

  assign hit_bytes = (rd_addr == ADDR_W'(OFS_BYTES));
  assign hit_stat  = (rd_addr == ADDR_W'(OFS_STATUS));
  assign pop       = rd_en & hit_stat & ~empty;

  always_comb begin
    sel_word = '0;
    if (!empty) begin
      if (hit_bytes)     sel_word = bytes_word;
      else if (hit_stat) sel_word = stat_word(head_stat);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel_word : '0;
    end
  end
endmodule

// File: rtl/dma_resp_queue.sv
module dma_resp_queue
  import dma_resp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int BYTES_W = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [BYTES_W-1:0] rsp_bytes,
  input  logic [ERR_W-1:0]   rsp_err,
  input  logic               rsp_early,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [LEVEL_W-1:0] q_level,
  output logic               q_empty,
  output logic               q_full,
  output logic               q_overflow
);
  localparam int DATA_W = BYTES_W + ERR_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              accept, pop, st_empty, st_full;
  logic [DATA_W-1:0] wr_word, head_word;
  logic [CNT_W-1:0]  cnt;
  resp_stat_t        in_stat, head_stat;

  assign in_stat.err   = rsp_err;
  assign in_stat.early = rsp_early;
  assign wr_word       = {in_stat, rsp_bytes};
  assign head_stat     = head_word[DATA_W-1:BYTES_W];

  resp_push_guard u_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(rsp_valid), .store_full(st_full),
    .in_ready(rsp_ready), .accept(accept), .overflow(q_overflow)
  );

  resp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(wr_word), .pop(pop),
    .head(head_word), .count(cnt), .empty(st_empty), .full(st_full)
  );

  resp_window #(.BYTES_W(BYTES_W), .ADDR_W(ADDR_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .empty(st_empty), .head_bytes(head_word[BYTES_W-1:0]),
    .head_stat(head_stat), .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign q_level = LEVEL_W'(cnt);
  assign q_empty = st_empty;
  assign q_full  = st_full;
endmodule

// File: rtl/dma_resp_queue_chk.sv
module dma_resp_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic [15:0]       q_level,
  input logic              q_empty,
  input logic              q_full,
  input logic              q_overflow
);
  logic stat_rd;
  assign stat_rd = rd_en && (rd_addr == ADDR_W'(4)) && !q_empty;

  // R2
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !stat_rd) |=> (q_level == $past(q_level) + 16'd1));
  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && q_full && !stat_rd) |=> (q_overflow && $stable(q_level)));
  // R3
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |=> q_overflow);
  // R5
  a_r5_stat_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rsp_valid) |=> (q_level == $past(q_level) - 16'd1));
  // R7
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty && !rsp_valid) |=> (rd_data == 32'd0 && q_level == 16'd0));
  // R8
  a_r8_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R9
  a_r9_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !rsp_ready);
  // R9
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
  // R12
  a_r12_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= 16'(DEPTH));
endmodule

bind dma_resp_queue dma_resp_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .q_level(q_level), .q_empty(q_empty), .q_full(q_full), .q_overflow(q_overflow)
);

// File: tb/sim_dma_resp_queue.sv
module sim_dma_resp_queue;
  localparam int DEPTH = 4;
  localparam int BW    = 32;
  localparam int AW    = 4;

  logic clk = 0, rst_n = 0;
  logic rsp_valid = 0, rsp_early = 0, rd_en = 0;
  logic [BW-1:0] rsp_bytes = '0;
  logic [7:0] rsp_err = '0;
  logic [AW-1:0] rd_addr = '0;
  logic rsp_ready, rd_valid, q_empty, q_full, q_overflow;
  logic [31:0] rd_data;
  logic [15:0] q_level;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [40:0] model[$];

  always #2 clk = ~clk;

  dma_resp_queue #(.DEPTH(DEPTH), .BYTES_W(BW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_bytes(rsp_bytes), .rsp_err(rsp_err), .rsp_early(rsp_early),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .q_level(q_level), .q_empty(q_empty), .q_full(q_full), .q_overflow(q_overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] b, input logic [7:0] e, input logic ea);
    @(negedge clk);
    rsp_valid = 1; rsp_bytes = b; rsp_err = e; rsp_early = ea;
    if (model.size() < DEPTH) model.push_back({ea, e, b});
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(posedge clk); #1;
    d = rd_data;
    chk(rd_valid == 1'b1, "R8 rd_valid after read", 32'(rd_valid), 32'd1);
    rd_en = 0;
    if (a == AW'(4) && model.size() > 0) void'(model.pop_front());
  endtask

  function automatic logic [31:0] exp_stat(logic [40:0] m);
    return {23'd0, m[40], m[39:32]};
  endfunction

  task automatic lvl(input string tag);
    chk(q_level == 16'(model.size()), tag, 32'(q_level), 32'(model.size()));
    chk(q_empty == (model.size() == 0), {tag, " empty"}, 32'(q_empty), 32'(model.size() == 0));
    chk(q_full == (model.size() == DEPTH), {tag, " full"}, 32'(q_full), 32'(model.size() == DEPTH));
  endtask

  task automatic t_reset;
    chk(q_empty == 1, "R1 empty", 32'(q_empty), 1);
    chk(q_full == 0, "R1 full", 32'(q_full), 0);
    chk(q_level == 0, "R1 level", 32'(q_level), 0);
    chk(q_overflow == 0, "R1 overflow", 32'(q_overflow), 0);
    chk(rsp_ready == 1, "R1 ready", 32'(rsp_ready), 1);
    chk(rd_valid == 0, "R8 idle rd_valid", 32'(rd_valid), 0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    logic [40:0] m;
    push(32'hCAFE_0100, 8'h5A, 1'b1);
    lvl("R2 R12 level after push");
    m = model[0];
    rd(AW'(0), d); chk(d == m[31:0], "R4 bytes word", d, m[31:0]);
    rd(AW'(0), d); chk(d == m[31:0], "R4 repeat bytes", d, m[31:0]);
    lvl("R4 no pop on bytes read");
    rd(AW'(4), d); chk(d == exp_stat(m), "R5 status word", d, exp_stat(m));
    lvl("R5 pop on status read");
  endtask

  task automatic t_order;
    logic [31:0] d;
    logic [40:0] m;
    push(32'd11, 8'h01, 0); push(32'd22, 8'h00, 1); push(32'd33, 8'hFF, 0);
    for (int i = 0; i < 3; i++) begin
      m = model[0];
      rd(AW'(0), d); chk(d == m[31:0], "R6 order bytes", d, m[31:0]);
      rd(AW'(4), d); chk(d == exp_stat(m), "R6 order status", d, exp_stat(m));
    end
    lvl("R6 drained");
  endtask

  task automatic t_full;
    logic [31:0] d;
    logic [40:0] m;
    for (int i = 0; i < DEPTH; i++) push(32'h100 + 32'(i), 8'(i), 0);
    lvl("R9 full level");
    chk(rsp_ready == 0, "R9 ready low when full", 32'(rsp_ready), 0);
    chk(q_overflow == 0, "R3 no overflow yet", 32'(q_overflow), 0);
    push(32'hDEAD, 8'hEE, 1);
    chk(q_overflow == 1, "R3 overflow set", 32'(q_overflow), 1);
    lvl("R3 level unchanged");
    for (int i = 0; i < DEPTH; i++) begin
      m = model[0];
      rd(AW'(0), d); chk(d == m[31:0], "R3 contents kept", d, m[31:0]);
      rd(AW'(4), d); chk(d == exp_stat(m), "R3 status kept", d, exp_stat(m));
    end
    lvl("R3 drained");
    chk(q_overflow == 1, "R3 overflow sticky", 32'(q_overflow), 1);
  endtask

  task automatic t_empty_read;
    logic [31:0] d;
    rd(AW'(4), d); chk(d == 0, "R7 empty status zero", d, 0);
    rd(AW'(0), d); chk(d == 0, "R7 empty bytes zero", d, 0);
    lvl("R7 level stays zero");
    push(32'h77, 8'h03, 0);
    lvl("R7 push after empty read");
    rd(AW'(0), d); chk(d == 32'h77, "R7 no underflow bytes", d, 32'h77);
    rd(AW'(4), d); chk(d == 32'h03, "R7 no underflow status", d, 32'h03);
    lvl("R7 empty again");
  endtask

  task automatic t_bad_addr;
    logic [31:0] d;
    push(32'h44, 8'h10, 1);
    rd(AW'(8), d);  chk(d == 0, "R10 offset 8 zero", d, 0);
    rd(AW'(12), d); chk(d == 0, "R10 offset C zero", d, 0);
    rd(AW'(2), d);  chk(d == 0, "R10 offset 2 zero", d, 0);
    lvl("R10 no pop");
    rd(AW'(0), d);  chk(d == 32'h44, "R10 head intact", d, 32'h44);
    rd(AW'(4), d);  chk(d == 32'h110, "R10 status intact", d, 32'h110);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    push(32'hA1, 8'h21, 0);
    @(negedge clk);
    rsp_valid = 1; rsp_bytes = 32'hB2; rsp_err = 8'h42; rsp_early = 1;
    rd_en = 1; rd_addr = AW'(4);
    @(posedge clk); #1;
    rsp_valid = 0; rd_en = 0;
    chk(rd_data == 32'h21, "R11 old head status", rd_data, 32'h21);
    chk(q_level == 1, "R11 level kept", 32'(q_level), 1);
    void'(model.pop_front()); model.push_back({1'b1, 8'h42, 32'hB2});
    rd(AW'(0), d); chk(d == 32'hB2, "R11 new head bytes", d, 32'hB2);
    rd(AW'(4), d); chk(d == 32'h142, "R11 new head status", d, 32'h142);
    lvl("R11 drained");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_single();
    t_order();
    t_empty_read();
    t_bad_addr();
    t_simul();
    t_full();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule